// File: doc/BRIEF.md
# Two-Level Process Dispatcher

This block decides which of many processes owns a single execution unit. Processes come in two classes. Urgent (high) processes run until they give up the unit. Background (low) processes take turns in round-robin order. A background process gets a budget of timeslice ticks, and when the budget runs out it goes to the back of its queue. Each class has a ready queue. The queue is a singly linked list threaded through a per-process link memory, with one register for the front and one for the back.

A process enters a queue through a make-ready request that carries its identifier and class. The running process leaves the unit by raising a block line (it waits on I/O or a timer) or a stop line. An urgent process that becomes ready while a background process runs takes the unit in the next cycle. The interrupted background process waits in a dedicated side slot, keeps its tick count, and returns before any queued background process. A freed unit is refilled in the same cycle from the best waiting candidate. The unit therefore stays idle only when nothing is waiting.

Top module: `proc_dispatcher`

## Requirements
- R1: After reset no process runs: `runValid` is 0.
- R2: A make-ready request seen while the unit is idle puts that process on the unit from the next clock edge, with `runId` equal to the request's identifier and `runHigh` equal to its class (1 = high, 0 = low).
- R3: A running high process stays on the unit through any number of ticks and leaves only when `blockReq` or `stopReq` is raised.
- R4: A high process made ready while another high process runs waits. Waiting high processes are dispatched in arrival order.
- R5: At its second counted tick, a running low process moves to the back of the low queue, and the front of that queue takes the unit in the same edge.
- R6: A process that blocks or stops leaves the unit at the next edge. Ticks and other processes' activity never bring it back unless it is made ready again.
- R7: A high request that arrives while a low process runs takes the unit at the next edge. When no high work remains, the interrupted low process resumes ahead of every queued low process.
- R8: A resumed low process keeps the tick it had counted before the interruption. It is therefore descheduled at its next tick.
- R9: Ticks are counted only while a low process runs. The count restarts at zero whenever a low process is dispatched, including a sole low process that is re-dispatched after its slice ends.
- R10: When a make-ready request and a block arrive in the same cycle, the block is applied first. A high request therefore takes the freed unit ahead of queued low processes.
- R11: `runValid` is 0 only when both queues are empty and no interrupted process is held. A sole low process whose slice expires keeps the unit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| readyReq | input | 1 | Make-ready request strobe |
| readyId | input | ID_W | Identifier of the process being made ready |
| readyHigh | input | 1 | Class of that process: 1 high, 0 low |
| blockReq | input | 1 | Running process waits on I/O or a timer |
| stopReq | input | 1 | Running process stops |
| tick | input | 1 | Periodic timeslice pulse |
| runValid | output | 1 | A process owns the unit |
| runId | output | ID_W | Identifier of the running process |
| runHigh | output | 1 | Class of the running process |

## Verification
The hardest state to reach is an interrupted low process that has already used half its slice while another low process sits in the queue. Only this state shows that the resume order and the saved count both hold. The stimulus builds it in a fixed order. It starts one low process and queues a second one. It delivers exactly one tick, then issues a high request. While the high process runs it sends ticks that must not count. It then blocks the high process and expects the interrupted process back, and expects the next single tick to rotate it out. A second hard state is a block and a request in the same cycle with low work queued. It is reached by driving both strobes in the same cycle.

// File: rtl/disp_pkg.sv
package disp_pkg;

  // source feeding the running-process register on a load
  typedef enum logic [1:0] {
    SEL_HI_FRONT = 2'd0,
    SEL_LO_FRONT = 2'd1,
    SEL_REQ      = 2'd2,
    SEL_PRM      = 2'd3
  } run_sel_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic     hiPush;     // append request id to high queue
    logic     hiPop;      // take front of high queue
    logic     loPushOld;  // append running id to low queue (slice expiry)
    logic     loPushNew;  // append request id to low queue (after loPushOld)
    logic     loPop;      // take front of low queue
    logic     runLoad;    // load running register from runSel
    run_sel_e runSel;
    logic     runClear;   // unit becomes idle
    logic     prmSave;    // park running low process in side slot
    logic     prmClear;   // side slot consumed
  } strobe_t;

endpackage

// File: rtl/ready_list.sv
module ready_list #(
  parameter int NUM_PROCS = 16,
  parameter int ID_W      = $clog2(NUM_PROCS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push0,
  input  logic [ID_W-1:0] data0,
  input  logic            push1,
  input  logic [ID_W-1:0] data1,
  input  logic            pop,
  output logic [ID_W-1:0] front,
  output logic            empty
);

  logic [ID_W-1:0] link [NUM_PROCS];
  logic [ID_W-1:0] back;
  logic [ID_W-1:0] frontNext, backNext, tail1;
  logic            remEmpty, emptyNext;

  // list left after the pop, before the appends
  always_comb begin
    remEmpty  = empty | (pop & (front == back));
    frontNext = front;
    backNext  = back;
    if (pop) frontNext = link[front];
    if (remEmpty) frontNext = push0 ? data0 : data1;
    if (push1)      backNext = data1;
    else if (push0) backNext = data0;
    emptyNext = remEmpty & ~push0 & ~push1;
    tail1     = push0 ? data0 : back;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      front <= '0;
      back  <= '0;
      empty <= 1'b1;
      for (int i = 0; i < NUM_PROCS; i++) link[i] <= '0;
    end else begin
      front <= frontNext;
      back  <= backNext;
      empty <= emptyNext;
      if (push0) link[back]  <= data0;
      if (push1) link[tail1] <= data1;
    end
  end

  // R5: never take an entry from an empty queue
  p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R5: the queue is non-empty after any append
  p_push_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push0 | push1) |=> !empty);

endmodule

// File: rtl/disp_datapath.sv
module disp_datapath
  import disp_pkg::*;
#(
  parameter int NUM_PROCS = 16,
  parameter int ID_W      = $clog2(NUM_PROCS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  strobe_t         stb,
  input  logic [ID_W-1:0] readyId,
  input  logic            readyHigh,
  output logic            runValid,
  output logic [ID_W-1:0] runId,
  output logic            runHigh,
  output logic            prmValid,
  output logic            hiEmpty,
  output logic            loEmpty
);

  localparam int NQ = 2;  // queue 0 high, queue 1 low

  logic [NQ-1:0]   qPush0, qPush1, qPop, qEmpty;
  logic [ID_W-1:0] qData0 [NQ];
  logic [ID_W-1:0] qFront [NQ];
  logic [ID_W-1:0] prmId;

  assign qPush0[0] = 1'b0;
  assign qData0[0] = runId;
  assign qPush1[0] = stb.hiPush;
  assign qPop[0]   = stb.hiPop;
  assign qPush0[1] = stb.loPushOld;
  assign qData0[1] = runId;
  assign qPush1[1] = stb.loPushNew;
  assign qPop[1]   = stb.loPop;

  for (genvar gq = 0; gq < NQ; gq++) begin : g_queue
    ready_list #(.NUM_PROCS(NUM_PROCS), .ID_W(ID_W)) list_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push0 (qPush0[gq]),
      .data0 (qData0[gq]),
      .push1 (qPush1[gq]),
      .data1 (readyId),
      .pop   (qPop[gq]),
      .front (qFront[gq]),
      .empty (qEmpty[gq])
    );
  end

  assign hiEmpty = qEmpty[0];
  assign loEmpty = qEmpty[1];

  logic [ID_W-1:0] loadId;
  logic            loadHigh;

  always_comb begin
    unique case (stb.runSel)
      SEL_HI_FRONT: begin loadId = qFront[0]; loadHigh = 1'b1;      end
      SEL_LO_FRONT: begin loadId = qFront[1]; loadHigh = 1'b0;      end
      SEL_REQ:      begin loadId = readyId;   loadHigh = readyHigh; end
      default:      begin loadId = prmId;     loadHigh = 1'b0;      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runValid <= 1'b0;
      runId    <= '0;
      runHigh  <= 1'b0;
      prmValid <= 1'b0;
      prmId    <= '0;
    end else begin
      if (stb.runLoad) begin
        runValid <= 1'b1;
        runId    <= loadId;
        runHigh  <= loadHigh;
      end else if (stb.runClear) begin
        runValid <= 1'b0;
      end
      if (stb.prmSave) begin
        prmValid <= 1'b1;
        prmId    <= runId;
      end else if (stb.prmClear) begin
        prmValid <= 1'b0;
      end
    end
  end

  // R7: only a running low process may be parked
  p_save_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.prmSave |-> (runValid && !runHigh && !prmValid));

  // R7: a parked process is resumed only onto a free unit, never twice
  p_resume_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.prmClear |=> !prmValid);

endmodule

// File: rtl/disp_ctrl.sv
module disp_ctrl
  import disp_pkg::*;
#(
  parameter int SLICE_TICKS = 2,
  parameter int CNT_W       = $clog2(SLICE_TICKS + 1)
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    readyReq,
  input  logic    readyHigh,
  input  logic    blockReq,
  input  logic    stopReq,
  input  logic    tick,
  input  logic    runValid,
  input  logic    runHigh,
  input  logic    prmValid,
  input  logic    hiEmpty,
  input  logic    loEmpty,
  output strobe_t stb
);

  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(SLICE_TICKS - 1);

  logic [CNT_W-1:0] cnt, cntNext, prmCnt, prmCntNext;
  logic keep, expire, reqHi, reqLo, preempt, busy;

  always_comb begin
    keep    = runValid & ~(blockReq | stopReq);   // block applied first (R10)
    expire  = keep & ~runHigh & tick & (cnt == LAST_TICK);
    reqHi   = readyReq & readyHigh;
    reqLo   = readyReq & ~readyHigh;
    preempt = keep & ~expire & ~runHigh & reqHi;
    busy    = keep & ~expire;

    stb        = '0;
    stb.runSel = SEL_REQ;
    cntNext    = cnt;
    prmCntNext = prmCnt;

    if (preempt) begin
      stb.prmSave = 1'b1;
      stb.runLoad = 1'b1;
      stb.runSel  = SEL_REQ;
      prmCntNext  = cnt;
    end else if (busy) begin
      stb.hiPush    = reqHi;
      stb.loPushNew = reqLo;
      if (tick && !runHigh) cntNext = cnt + 1'b1;
    end else begin
      // unit is free this edge: pick best candidate
      stb.loPushOld = expire;
      if (!hiEmpty) begin
        stb.hiPop     = 1'b1;
        stb.runLoad   = 1'b1;
        stb.runSel    = SEL_HI_FRONT;
        stb.hiPush    = reqHi;
        stb.loPushNew = reqLo;
      end else if (reqHi) begin
        stb.runLoad = 1'b1;
        stb.runSel  = SEL_REQ;
      end else if (prmValid) begin
        stb.runLoad   = 1'b1;
        stb.runSel    = SEL_PRM;
        stb.prmClear  = 1'b1;
        stb.loPushNew = reqLo;
        cntNext       = prmCnt;
      end else if (!loEmpty) begin
        stb.loPop     = 1'b1;
        stb.runLoad   = 1'b1;
        stb.runSel    = SEL_LO_FRONT;
        stb.loPushNew = reqLo;
        cntNext       = '0;
      end else if (expire) begin
        // sole low process: it keeps the unit with a fresh slice
        stb.loPushOld = 1'b0;
        stb.loPushNew = reqLo;
        cntNext       = '0;
      end else if (reqLo) begin
        stb.runLoad = 1'b1;
        stb.runSel  = SEL_REQ;
        cntNext     = '0;
      end else begin
        stb.runClear = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      prmCnt <= '0;
    end else begin
      cnt    <= cntNext;
      prmCnt <= prmCntNext;
    end
  end

  // R3: a high process survives ticks while neither block nor stop is raised
  p_high_no_slice_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (runValid && runHigh && !blockReq && !stopReq) |=> (runValid && runHigh));

  // R11: idle only when nothing at all is waiting
  p_idle_means_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !runValid |-> (hiEmpty && loEmpty && !prmValid));

  // R7: a parked low process exists only beneath a running high process
  p_parked_under_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prmValid |-> (runValid && runHigh));

  // R7: a low process never runs while high work waits
  p_low_only_without_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (runValid && !runHigh) |-> hiEmpty);

  // R9: counted ticks stay inside the slice
  p_cnt_in_slice_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < CNT_W'(SLICE_TICKS)) && (prmCnt < CNT_W'(SLICE_TICKS)));

endmodule

// File: rtl/proc_dispatcher.sv
module proc_dispatcher
  import disp_pkg::*;
#(
  parameter int NUM_PROCS   = 16,
  parameter int SLICE_TICKS = 2,
  parameter int ID_W        = $clog2(NUM_PROCS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            readyReq,
  input  logic [ID_W-1:0] readyId,
  input  logic            readyHigh,
  input  logic            blockReq,
  input  logic            stopReq,
  input  logic            tick,
  output logic            runValid,
  output logic [ID_W-1:0] runId,
  output logic            runHigh
);

  strobe_t stb;
  logic    prmValid, hiEmpty, loEmpty;

  disp_ctrl #(.SLICE_TICKS(SLICE_TICKS)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .readyReq  (readyReq),
    .readyHigh (readyHigh),
    .blockReq  (blockReq),
    .stopReq   (stopReq),
    .tick      (tick),
    .runValid  (runValid),
    .runHigh   (runHigh),
    .prmValid  (prmValid),
    .hiEmpty   (hiEmpty),
    .loEmpty   (loEmpty),
    .stb       (stb)
  );

  disp_datapath #(.NUM_PROCS(NUM_PROCS), .ID_W(ID_W)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .readyId   (readyId),
    .readyHigh (readyHigh),
    .runValid  (runValid),
    .runId     (runId),
    .runHigh   (runHigh),
    .prmValid  (prmValid),
    .hiEmpty   (hiEmpty),
    .loEmpty   (loEmpty)
  );

endmodule

// File: tb/proc_dispatcher_tb.sv
module proc_dispatcher_tb_top;

  localparam int ID_W = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            readyReq = 1'b0, readyHigh = 1'b0;
  logic [ID_W-1:0] readyId = '0;
  logic            blockReq = 1'b0, stopReq = 1'b0, tick = 1'b0;
  logic            runValid, runHigh;
  logic [ID_W-1:0] runId;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  proc_dispatcher #(.NUM_PROCS(16), .SLICE_TICKS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .readyReq(readyReq), .readyId(readyId),
    .readyHigh(readyHigh), .blockReq(blockReq), .stopReq(stopReq), .tick(tick),
    .runValid(runValid), .runId(runId), .runHigh(runHigh)
  );

  // drive one cycle of strobes, then sample just after the edge that takes them
  task automatic drive(input logic rq, input int id, input logic hi,
                       input logic blk, input logic stp, input logic tk);
    readyReq = rq; readyId = ID_W'(id); readyHigh = hi;
    blockReq = blk; stopReq = stp; tick = tk;
    @(posedge clk); #2;
    readyReq = 0; blockReq = 0; stopReq = 0; tick = 0;
  endtask

  task automatic mkReady(input int id, input logic hi); drive(1, id, hi, 0, 0, 0); endtask
  task automatic doBlock();                          drive(0, 0, 0, 1, 0, 0); endtask
  task automatic doStop();                           drive(0, 0, 0, 0, 1, 0); endtask
  task automatic doTick();                           drive(0, 0, 0, 0, 0, 1); endtask

  task automatic expectRun(input string req, input logic v, input int id, input logic hi);
    checks++;
    if (runValid !== v || (v && (runId !== ID_W'(id) || runHigh !== hi))) begin
      errors++;
      $display("FAIL %s: got valid=%0b id=%0d high=%0b, expected valid=%0b id=%0d high=%0b",
               req, runValid, runId, runHigh, v, id, hi);
    end
  endtask

  task automatic testReset();
    expectRun("R1 reset idle", 0, 0, 0);
  endtask

  task automatic testBasic();
    mkReady(3, 0);  expectRun("R2 idle dispatch low", 1, 3, 0);
    doBlock();      expectRun("R6 block leaves unit", 0, 0, 0);
    doTick(); doTick();
    expectRun("R6 blocked stays off", 0, 0, 0);
  endtask

  task automatic testHigh();
    mkReady(5, 1);  expectRun("R2 idle dispatch high", 1, 5, 1);
    for (int i = 0; i < 3; i++) doTick();
    expectRun("R3 high not sliced", 1, 5, 1);
    mkReady(6, 1);  expectRun("R4 second high waits", 1, 5, 1);
    mkReady(7, 1);
    doStop();       expectRun("R4 fifo first", 1, 6, 1);
    doBlock();      expectRun("R4 fifo second", 1, 7, 1);
    doBlock();      expectRun("R11 idle when empty", 0, 0, 0);
  endtask

  task automatic testRoundRobin();
    mkReady(1, 0); mkReady(2, 0); mkReady(4, 0);
    doTick();       expectRun("R9 first tick counted only", 1, 1, 0);
    doTick();       expectRun("R5 rotate after 2nd tick", 1, 2, 0);
    doTick();       expectRun("R9 count restarted", 1, 2, 0);
    doTick();       expectRun("R5 rotate to third", 1, 4, 0);
    doTick(); doTick();
    expectRun("R5 rotated one back to front", 1, 1, 0);
    doBlock();      expectRun("R5 order after rotation", 1, 2, 0);
    doBlock();      expectRun("R5 last in list", 1, 4, 0);
    doBlock();      expectRun("R11 idle after drain", 0, 0, 0);
  endtask

  task automatic testPreempt();
    mkReady(8, 0); mkReady(9, 0);
    doTick();       expectRun("R9 one tick on 8", 1, 8, 0);
    mkReady(10, 1); expectRun("R7 high preempts low", 1, 10, 1);
    doTick(); doTick(); doTick();
    expectRun("R3 high through ticks", 1, 10, 1);
    doBlock();      expectRun("R7 parked low resumes first", 1, 8, 0);
    doTick();       expectRun("R8 kept count expires at next tick", 1, 9, 0);
    doBlock();      expectRun("R5 8 was appended", 1, 8, 0);
    doBlock();      expectRun("R11 idle after preempt test", 0, 0, 0);
  endtask

  task automatic testSameCycle();
    mkReady(11, 1); mkReady(12, 0);
    expectRun("R7 low waits behind high", 1, 11, 1);
    drive(1, 13, 1, 1, 0, 0);
    expectRun("R10 block first then high request", 1, 13, 1);
    doBlock();      expectRun("R10 queued low after high", 1, 12, 0);
    doBlock();      expectRun("R11 idle after same-cycle test", 0, 0, 0);
  endtask

  task automatic testSolo();
    mkReady(14, 0);
    doTick(); doTick();
    expectRun("R11 sole low keeps unit", 1, 14, 0);
    doTick();       expectRun("R9 fresh slice after redispatch", 1, 14, 0);
    mkReady(15, 0);
    doTick();       expectRun("R5 rotate to newcomer", 1, 15, 0);
    doStop();       expectRun("R6 stop then 14 back", 1, 14, 0);
    doStop();       expectRun("R6 stopped stays off", 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    testReset();
    rst_n = 1'b1;
    @(posedge clk); #2;
    testReset();
    testBasic();
    testHigh();
    testRoundRobin();
    testPreempt();
    testSameCycle();
    testSolo();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule